// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block picks the single interrupt line, out of eight, that should be raised to the processor in a given cycle. It works from three vectors: pending requests, a mask and the set of lines already in service. Priority is not fixed. A 3-bit rotation base sets which line holds the top position, and the other lines follow it in ascending order with wrap-around. A pending request is only raised when it ranks strictly above every line that is already in service.

When nested mode is enabled on a master instance, the cascade line is not counted in the in-service comparison. This lets a second request arriving through the cascade line preempt the one already being served on it. Register programming, acknowledge handling and cascading logic sit in neighbouring blocks. This block takes their state as plain inputs and returns a registered decision every clock.

Top module: `prio_resolver`

## Requirements
- R1: A line whose mask bit is 1 is never reported. The candidate set is `req_vec & ~mask_vec`.
- R2: Level p is the position of line `(p + rot_base) mod 8`, and level 0 is the highest priority. Among the candidates, the one with the smallest level is chosen.
- R3: When the candidate set is empty, `irq_valid` is 0.
- R4: `irq_valid` is 1 only when the best candidate level is strictly smaller than the best in-service level. An equal level yields 0.
- R5: When no in-service bit counts, any non-empty candidate set yields `irq_valid` = 1.
- R6: `irq_line` equals `(winning level + rot_base) mod 8`, which is the index of the winning line in `req_vec`.
- R7: When `nested_en` = 1 and `is_master` = 1, in-service bit 2 (the cascade line) is ignored when the in-service vector is ranked.
- R8: When either `nested_en` or `is_master` is 0, in-service bit 2 is ranked like any other bit.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising edge of `clk` and do not change between edges. While `rst_n` is 0, the outputs are `irq_valid` = 0 and `irq_line` = 0.
- R10: Whenever `irq_valid` is 0, `irq_line` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vec | input | 8 | Pending request bits, one per line |
| mask_vec | input | 8 | Mask bits; 1 blocks the line |
| isr_vec | input | 8 | In-service bits, one per line |
| rot_base | input | 3 | Line that holds priority level 0 |
| nested_en | input | 1 | Nested mode enable |
| is_master | input | 1 | 1 when this instance is the master |
| irq_valid | output | 1 | An interrupt should be raised |
| irq_line | output | 3 | Winning line number, 0 when not valid |

## Verification
Two rankings are decided in the same cycle: the best pending request and the best in-service level. The outcome depends on how the two compare. The bench provokes the contested case by putting a line in service at exactly the same level as the best candidate, and at levels one above and one below it. Equal levels must yield no interrupt, and only a strictly smaller pending level may win. The cascade exclusion is provoked by holding bit 2 in service under every combination of `nested_en` and `is_master`. Every result, and a sweep of all rotation bases with random vectors, is judged against a loop-based reference model in the bench.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_CASCADE = 2;

  function automatic int unsigned wrap_sum(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned n);
    return (a + b) % n;
  endfunction
endpackage

// File: rtl/prio_rotate.sv
module prio_rotate #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic [N-1:0]  rot
);
  // rot[p] holds the bit of the line that sits at level p
  always_comb begin
    for (int unsigned p = 0; p < N; p++) begin
      rot[p] = vec[prio_pkg::wrap_sum(p, int'(base), N)];
    end
  end
endmodule

// File: rtl/prio_first_set.sv
module prio_first_set #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [LW-1:0] level
);
  // lowest set position; N acts as the "nothing found" sentinel
  always_comb begin
    level = LW'(N);
    for (int p = int'(N) - 1; p >= 0; p--) begin
      if (vec[p]) level = LW'(p);
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int unsigned N           = prio_pkg::DEF_LINES,
  parameter int unsigned CASCADE_IDX = prio_pkg::DEF_CASCADE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_vec,
  input  logic [N-1:0]         mask_vec,
  input  logic [N-1:0]         isr_vec,
  input  logic [$clog2(N)-1:0] rot_base,
  input  logic                 nested_en,
  input  logic                 is_master,
  output logic                 irq_valid,
  output logic [$clog2(N)-1:0] irq_line
);
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned LW = $clog2(N + 1);
  localparam int unsigned NV = 2;  // 0: candidates, 1: in service

  logic [N-1:0]  src   [NV];
  logic [N-1:0]  rot   [NV];
  logic [LW-1:0] level [NV];

  logic [N-1:0] cascade_bit;
  always_comb begin
    cascade_bit = '0;
    cascade_bit[CASCADE_IDX] = nested_en & is_master;
  end

  assign src[0] = req_vec & ~mask_vec;
  assign src[1] = isr_vec & ~cascade_bit;

  generate
    for (genvar v = 0; v < NV; v++) begin : g_rank
      prio_rotate #(.N(N), .IW(IW)) u_rot (
        .vec  (src[v]),
        .base (rot_base),
        .rot  (rot[v])
      );
      prio_first_set #(.N(N), .LW(LW)) u_first (
        .vec   (rot[v]),
        .level (level[v])
      );
    end
  endgenerate

  logic          win_d;
  logic [IW-1:0] line_d;

  always_comb begin
    win_d  = level[0] < level[1];
    line_d = '0;
    if (win_d) begin
      line_d = IW'(prio_pkg::wrap_sum(int'(level[0]), int'(rot_base), N));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_line  <= '0;
    end else begin
      irq_valid <= win_d;
      irq_line  <= line_d;
    end
  end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int unsigned N           = 8,
  parameter int unsigned CASCADE_IDX = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         req_vec,
  input logic [N-1:0]         mask_vec,
  input logic [N-1:0]         isr_vec,
  input logic [$clog2(N)-1:0] rot_base,
  input logic                 nested_en,
  input logic                 is_master,
  input logic                 irq_valid,
  input logic [$clog2(N)-1:0] irq_line
);
  // R1: the reported line was an unmasked pending request one cycle earlier
  a_r1_unmasked_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> |(((($past(req_vec) & ~$past(mask_vec))) >> irq_line) & N'(1)));

  // R3: an empty candidate set gives no interrupt on the next cycle
  a_r3_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_vec & ~mask_vec) == '0) |=> !irq_valid);

  // R4: the winner is never a line already in service, unless it is the
  // cascade line that nested mode on the master leaves out of the ranking
  a_r4_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !($past(nested_en) && $past(is_master) &&
                    (int'(irq_line) == int'(CASCADE_IDX))))
    |-> !(|(($past(isr_vec) >> irq_line) & N'(1))));

  // R5: nothing counts in service and a candidate exists: an interrupt follows
  a_r5_free_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_vec == '0) && ((req_vec & ~mask_vec) != '0)) |=> irq_valid);

  // R10: the line output is zero whenever no interrupt is raised
  a_r10_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_line == '0));
endmodule

bind prio_resolver prio_resolver_chk #(.N(N), .CASCADE_IDX(CASCADE_IDX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vec   (req_vec),
  .mask_vec  (mask_vec),
  .isr_vec   (isr_vec),
  .rot_base  (rot_base),
  .nested_en (nested_en),
  .is_master (is_master),
  .irq_valid (irq_valid),
  .irq_line  (irq_line)
);

// File: tb/prio_resolver_test.sv
`timescale 1ns/1ps
module prio_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_vec = '0, mask_vec = '0, isr_vec = '0;
  logic [2:0] rot_base = '0;
  logic       nested_en = 1'b0, is_master = 1'b0;
  logic       irq_valid;
  logic [2:0] irq_line;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prio_resolver uut (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
    .isr_vec(isr_vec), .rot_base(rot_base), .nested_en(nested_en),
    .is_master(is_master), .irq_valid(irq_valid), .irq_line(irq_line)
  );

  function automatic int ref_level(input logic [7:0] v, input logic [2:0] b);
    for (int p = 0; p < 8; p++) if (v[(p + int'(b)) % 8]) return p;
    return 8;
  endfunction

  function automatic logic [3:0] ref_pick(input logic [7:0] rq, input logic [7:0] mk,
                                          input logic [7:0] is, input logic [2:0] b,
                                          input logic ne, input logic ms);
    logic [7:0] isv = is;
    int pl, il;
    if (ne && ms) isv[2] = 1'b0;
    pl = ref_level(rq & ~mk, b);
    il = ref_level(isv, b);
    if (pl < il) return {1'b1, 3'((pl + int'(b)) % 8)};
    return 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual valid=%0b line=%0d, expected valid=%0b line=%0d",
               tag, act[3], act[2:0], exp[3], exp[2:0]);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, check at next falling edge
  task automatic apply(input string tag, input logic [7:0] rq, input logic [7:0] mk,
                       input logic [7:0] is, input logic [2:0] b,
                       input logic ne, input logic ms);
    req_vec = rq; mask_vec = mk; isr_vec = is; rot_base = b;
    nested_en = ne; is_master = ms;
    @(negedge clk);
    check(tag, {irq_valid, irq_line}, ref_pick(rq, mk, is, b, ne, ms));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R9 reset state", {irq_valid, irq_line}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset idle", {irq_valid, irq_line}, 4'b0000);

    // R1 R3: everything masked
    apply("R1 R3 all masked", 8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0);
    check("R10 idle line zero", {irq_valid, irq_line}, 4'b0000);
    apply("R1 mask hides best", 8'b0000_0110, 8'b0000_0010, 8'h00, 3'd0, 1'b0, 1'b0);
    check("R1 expect line 2", {irq_valid, irq_line}, 4'b1010);

    // R2 R6: two requests, rotation decides; base 5 => line 6 beats line 3
    apply("R2 R6 rotate base5", 8'b0100_1000, 8'h00, 8'h00, 3'd5, 1'b0, 1'b0);
    check("R6 expect line 6", {irq_valid, irq_line}, 4'b1110);
    for (int b = 0; b < 8; b++)
      apply("R2 R6 all pending per base", 8'hFF, 8'h00, 8'h00, 3'(b), 1'b0, 1'b0);

    // R4: equal, higher and lower in-service levels (base 0, request line 4)
    apply("R4 equal level", 8'b0001_0000, 8'h00, 8'b0001_0000, 3'd0, 1'b0, 1'b0);
    check("R4 equal gives none", {irq_valid, irq_line}, 4'b0000);
    apply("R4 service above", 8'b0001_0000, 8'h00, 8'b0000_1000, 3'd0, 1'b0, 1'b0);
    apply("R4 service below", 8'b0001_0000, 8'h00, 8'b0010_0000, 3'd0, 1'b0, 1'b0);
    check("R4 lower service wins", {irq_valid, irq_line}, 4'b1100);

    // R5: nothing in service
    apply("R5 free wins", 8'b1000_0000, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0);

    // R7 R8: cascade line 2 in service, request on line 2 (base 0)
    apply("R7 nested master", 8'b0000_0100, 8'h00, 8'b0000_0100, 3'd0, 1'b1, 1'b1);
    check("R7 cascade ignored", {irq_valid, irq_line}, 4'b1010);
    apply("R8 nested slave", 8'b0000_0100, 8'h00, 8'b0000_0100, 3'd0, 1'b1, 1'b0);
    check("R8 slave counts bit2", {irq_valid, irq_line}, 4'b0000);
    apply("R8 master no nest", 8'b0000_0100, 8'h00, 8'b0000_0100, 3'd0, 1'b0, 1'b1);
    check("R8 no nest counts bit2", {irq_valid, irq_line}, 4'b0000);
    apply("R7 lower line behind cascade", 8'b0001_0000, 8'h00, 8'b0000_0100, 3'd0, 1'b1, 1'b1);

    // R9: outputs hold between edges after an input change
    apply("R9 setup", 8'b0000_0001, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
    req_vec = 8'h00;
    #3;
    check("R9 held before edge", {irq_valid, irq_line}, 4'b1000);
    @(negedge clk);
    check("R9 updated after edge", {irq_valid, irq_line}, 4'b0000);

    // random sweep over every base and mode
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 40; k++) begin
        apply("R1 R2 R4 R6 R7 random", 8'($urandom), 8'($urandom) & 8'($urandom),
              8'($urandom) & 8'($urandom), 3'(b), 1'($urandom), 1'($urandom));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule